// File: doc/BRIEF.md
# Capture Descriptor List Encoder

This block compiles a stream of capture requests into the packed descriptor list that a capture engine later walks. Each request carries a 16-byte-aligned base address, a byte offset from that base and a length in 32-bit words. The requests arrive over a valid/ready handshake. A final beat flagged as end-of-list closes the stream. The block writes the encoded list into a word-addressed SRAM, one word per cycle, starting at address 0.

The list uses two kinds of word. A base word carries bit 31 set and the base shifted right by four in bits 27:0. A pair word holds up to two 16-bit offset/length pairs. Each pair stores the word-offset delta from the previous request in bits 7:0 and the length in bits 14:8. A new base word appears only when the base changes or the offset moves backwards, so runs of nearby registers cost half a word each.

When the end beat arrives, the block flushes any half-filled word and writes a zero terminator. One cycle later it pulses `done` with the list length in words. It flags an error instead in three cases: an entry whose fields do not fit, a list with no entries, or a list that will not fit the SRAM. The SRAM check counts the captured data as well when the block runs in capture mode with the SRAM as data sink. On an error it also raises a request to zero the SRAM.

Top module: `desc_list_encoder`

## Requirements
- R1: A base word `{1'b1, 3'b000, base[31:4]}` is written for the first entry of a list, for an entry whose `base[31:4]` differs from the previous entry's, and for an entry whose word offset (`offset >> 2`) is below the previous entry's word offset.
- R2: The first pair of a word is held in bits 15:0, and a word holding only one pair is written with bits 31:16 = 16'h0001. A second pair fills bits 31:16, and the word `{secondPair, firstPair}` is written in the cycle that accepts that second entry.
- R3: A pair is `{1'b0, len[6:0], delta[7:0]}`. `delta` is the word offset minus the previous entry's word offset, and after a base word the previous offset counts as 0. A delta of 255 with a length of 127 is accepted.
- R4: If a base word is due while a half-filled word is pending, the half word is written first, with `inReady` low for exactly one cycle. The base word follows in the next cycle, and only then is the entry accepted.
- R5: On the end beat, a pending half word is written (with one stall cycle), then the word 32'h0. In the next cycle `done` is high with `error` low and `listWords` equal to the number of words written.
- R6: An entry with delta above 255 or `inLen` above 127 causes no write. Later entries of the same list are accepted and ignored. At the end beat, `done` comes with `error` = 1, `zeroReq` = 1 and `listWords` = 0.
- R7: An end beat with no entry before it in the list produces `done` with `error` = 1 and writes nothing.
- R8: With `capMode` = 1 and `sinkSram` = 1, the list is rejected when the words written, including the terminator, plus the sum of all entry lengths exceed `SRAM_WORDS`.
- R9: In any other mode pairing, only the list words, including the terminator, are compared with `SRAM_WORDS`.
- R10: Writes go to consecutive addresses from 0 in each list. No write enable is raised for a word whose index reaches `SRAM_WORDS`, and the next list starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capMode | input | 1 | 1 = capture function, 0 = checksum function |
| sinkSram | input | 1 | 1 = captured data goes to the SRAM, 0 = to the trace bus |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted this cycle |
| inEnd | input | 1 | Beat is the end-of-list marker (other fields ignored) |
| inBase | input | 32 | Base byte address, bits 3:0 ignored |
| inOffset | input | OFF_W | Byte offset from base, bits 1:0 ignored |
| inLen | input | LEN_W | Length in words |
| memWe | output | 1 | SRAM write enable |
| memAddr | output | ADDR_W | SRAM word address |
| memData | output | 32 | SRAM write data |
| done | output | 1 | One-cycle pulse after the end beat |
| error | output | 1 | With `done`: list rejected |
| zeroReq | output | 1 | With `done`: request to clear the SRAM |
| listWords | output | CNT_W | With `done` and no error: list length in words |

## Verification
The assertions assume that `capMode` and `sinkSram` stay fixed from the first entry of a list to its end beat. They also assume that a beat stays unchanged on the inputs while `inReady` is low. The stimulus changes modes only between lists, and the driver holds each beat until it sees `inReady`. A stalled beat is therefore re-evaluated with the same fields after the flush write.

// File: rtl/desc_enc_pkg.sv
package desc_enc_pkg;
  localparam int DELTA_W = 8;
  localparam int PLEN_W  = 7;

  typedef struct packed {
    logic wrFlush;
    logic wrBase;
    logic wrPair;
    logic wrTerm;
    logic take;
    logic load;
    logic setErr;
    logic finish;
  } encStrobe_t;

  typedef struct packed {
    logic newBase;
    logic halfVal;
    logic progErr;
    logic errSticky;
    logic firstPend;
  } encStatus_t;
endpackage

// File: rtl/desc_enc_ctrl.sv
module desc_enc_ctrl
  import desc_enc_pkg::*;
(
  input  logic       inValid,
  input  logic       inEnd,
  input  encStatus_t stat,
  output encStrobe_t st
);
  always_comb begin
    st = '0;
    if (inValid) begin
      if (!inEnd) begin
        if (stat.errSticky || stat.progErr) begin
          // drop the entry, remember the fault
          st.take   = 1'b1;
          st.setErr = stat.progErr;
        end else if (stat.newBase && stat.halfVal) begin
          // flush first; the entry is seen again next cycle
          st.wrFlush = 1'b1;
        end else begin
          st.take   = 1'b1;
          st.load   = 1'b1;
          st.wrBase = stat.newBase;
          st.wrPair = !stat.newBase && stat.halfVal;
        end
      end else begin
        if (stat.firstPend || stat.errSticky) begin
          st.take   = 1'b1;
          st.finish = 1'b1;
        end else if (stat.halfVal) begin
          st.wrFlush = 1'b1;
        end else begin
          st.wrTerm = 1'b1;
          st.take   = 1'b1;
          st.finish = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/desc_enc_dpath.sv
module desc_enc_dpath
  import desc_enc_pkg::*;
#(
  parameter int SRAM_WORDS = 64,
  parameter int OFF_W      = 16,
  parameter int LEN_W      = 8,
  parameter int CNT_W      = 16,
  localparam int ADDR_W    = $clog2(SRAM_WORDS),
  localparam int WOFF_W    = OFF_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capMode,
  input  logic              sinkSram,
  input  logic [31:0]       inBase,
  input  logic [OFF_W-1:0]  inOffset,
  input  logic [LEN_W-1:0]  inLen,
  input  encStrobe_t        st,
  output encStatus_t        stat,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              done,
  output logic              error,
  output logic              zeroReq,
  output logic [CNT_W-1:0]  listWords
);
  localparam logic [WOFF_W-1:0] DELTA_MAX = WOFF_W'((1 << DELTA_W) - 1);
  localparam logic [LEN_W-1:0]  LEN_MAX   = LEN_W'((1 << PLEN_W) - 1);
  localparam logic [CNT_W-1:0]  DEPTH     = CNT_W'(SRAM_WORDS);

  logic [27:0]        prevBase;
  logic [WOFF_W-1:0]  prevOff;
  logic [15:0]        halfPair;
  logic               halfVal, firstPend, errSticky;
  logic [CNT_W-1:0]   wordCnt, lenSum;

  logic [27:0]        baseW;
  logic [WOFF_W-1:0]  offW, refOff, delta;
  logic [15:0]        pairNew;
  logic               newBase, progErr, anyWr, overflow, finalErr;
  logic [CNT_W-1:0]   nextCnt, need;
  logic               unusedLowBits;

  assign unusedLowBits = ^{inBase[3:0], inOffset[1:0]};
  assign baseW   = inBase[31:4];
  assign offW    = inOffset[OFF_W-1:2];
  assign newBase = firstPend || (baseW != prevBase) || (offW < prevOff);
  assign refOff  = newBase ? '0 : prevOff;
  assign delta   = offW - refOff;
  assign progErr = (delta > DELTA_MAX) || (inLen > LEN_MAX);
  assign pairNew = {1'b0, inLen[PLEN_W-1:0], delta[DELTA_W-1:0]};

  assign stat = '{newBase: newBase, halfVal: halfVal, progErr: progErr,
                  errSticky: errSticky, firstPend: firstPend};

  always_comb begin
    if (st.wrFlush)     memData = {16'h0001, halfPair};
    else if (st.wrBase) memData = {1'b1, 3'b000, baseW};
    else if (st.wrPair) memData = {pairNew, halfPair};
    else                memData = 32'h0;
  end

  assign anyWr   = st.wrFlush | st.wrBase | st.wrPair | st.wrTerm;
  assign memWe   = anyWr && (wordCnt < DEPTH);
  assign memAddr = wordCnt[ADDR_W-1:0];

  assign nextCnt  = wordCnt + 1'b1;
  assign need     = (capMode && sinkSram) ? nextCnt + lenSum : nextCnt;
  assign overflow = need > DEPTH;
  assign finalErr = firstPend || errSticky || overflow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBase  <= '0;
      prevOff   <= '0;
      halfPair  <= '0;
      halfVal   <= 1'b0;
      firstPend <= 1'b1;
      errSticky <= 1'b0;
      wordCnt   <= '0;
      lenSum    <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      zeroReq   <= 1'b0;
      listWords <= '0;
    end else begin
      done      <= st.finish;
      error     <= st.finish && finalErr;
      zeroReq   <= st.finish && finalErr;
      listWords <= (st.finish && !finalErr) ? nextCnt : '0;
      if (anyWr)      wordCnt   <= nextCnt;
      if (st.wrFlush) halfVal   <= 1'b0;
      if (st.setErr)  errSticky <= 1'b1;
      if (st.load) begin
        prevBase  <= baseW;
        prevOff   <= offW;
        firstPend <= 1'b0;
        lenSum    <= lenSum + CNT_W'(inLen);
        if (newBase || !halfVal) begin
          halfVal  <= 1'b1;
          halfPair <= pairNew;
        end else begin
          halfVal  <= 1'b0;
        end
      end
      if (st.finish) begin
        firstPend <= 1'b1;
        halfVal   <= 1'b0;
        errSticky <= 1'b0;
        wordCnt   <= '0;
        lenSum    <= '0;
      end
    end
  end

  // R1
  base_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe && memData[31] |-> memData[30:28] == 3'b000);
  // R5
  term_before_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !error |-> $past(memWe) && $past(memData) == 32'h0);
  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> zeroReq && done && listWords == '0);
  // R10
  addr_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe && !st.finish |=> !memWe || memAddr == $past(memAddr) + 1'b1);
endmodule

// File: rtl/desc_list_encoder.sv
module desc_list_encoder
  import desc_enc_pkg::*;
#(
  parameter int SRAM_WORDS = 64,
  parameter int OFF_W      = 16,
  parameter int LEN_W      = 8,
  parameter int CNT_W      = 16,
  localparam int ADDR_W    = $clog2(SRAM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capMode,
  input  logic              sinkSram,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inEnd,
  input  logic [31:0]       inBase,
  input  logic [OFF_W-1:0]  inOffset,
  input  logic [LEN_W-1:0]  inLen,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              done,
  output logic              error,
  output logic              zeroReq,
  output logic [CNT_W-1:0]  listWords
);
  encStrobe_t st;
  encStatus_t stat;

  desc_enc_ctrl u_ctrl (
    .inValid(inValid), .inEnd(inEnd), .stat(stat), .st(st)
  );

  desc_enc_dpath #(
    .SRAM_WORDS(SRAM_WORDS), .OFF_W(OFF_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .capMode(capMode), .sinkSram(sinkSram),
    .inBase(inBase), .inOffset(inOffset), .inLen(inLen), .st(st),
    .stat(stat), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .done(done), .error(error), .zeroReq(zeroReq), .listWords(listWords)
  );

  assign inReady = st.take;

  // R4
  stall_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !inReady |-> st.wrFlush && !done);
endmodule

// File: tb/desc_list_encoder_bench.sv
module desc_list_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic capMode = 1'b1, sinkSram = 1'b1;
  logic inValid = 1'b0, inEnd = 1'b0;
  logic [31:0] inBase = '0;
  logic [15:0] inOffset = '0;
  logic [7:0]  inLen = '0;
  logic inReady, memWe, done, error, zeroReq;
  logic [5:0]  memAddr;
  logic [31:0] memData;
  logic [15:0] listWords;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_list_encoder #(.SRAM_WORDS(DEPTH)) u_desc_list_encoder (
    .clk(clk), .rstN(rstN), .capMode(capMode), .sinkSram(sinkSram),
    .inValid(inValid), .inReady(inReady), .inEnd(inEnd), .inBase(inBase),
    .inOffset(inOffset), .inLen(inLen), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .done(done), .error(error), .zeroReq(zeroReq),
    .listWords(listWords)
  );

  typedef struct { int addr; logic [31:0] data; string tag; } wr_t;
  typedef struct { logic err; int words; string tag; } res_t;
  wr_t  expW[$];
  res_t expR[$];

  int nChk = 0, nFail = 0;
  bit finished = 0;

  // reference model state
  bit mFirst = 1, mErr = 0, mHalf = 0;
  logic [27:0] mPrevBase = '0;
  int mPrevOff = 0, mCnt = 0, mLenSum = 0;
  logic [15:0] mHalfPair = '0;

  function automatic void expWr(input logic [31:0] d, input string tag);
    wr_t w;
    if (mCnt < DEPTH) begin
      w.addr = mCnt; w.data = d; w.tag = tag;
      expW.push_back(w);
    end
    mCnt++;
  endfunction

  function automatic void check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endfunction

  task automatic drive(output int stalls);
    bit ok;
    stalls = 0;
    inValid = 1'b1;
    forever begin
      #1;
      ok = inReady;
      @(negedge clk);
      if (ok) break;
      stalls++;
    end
  endtask

  task automatic sendEntry(input logic [31:0] b, input int off, input int len,
                           input string tag, output int stalls);
    logic [27:0] bw;
    int ow, d;
    bit nb;
    logic [15:0] pr;
    if (!mErr) begin
      bw = b[31:4]; ow = off / 4;
      nb = mFirst || bw != mPrevBase || ow < mPrevOff;
      d  = nb ? ow : ow - mPrevOff;
      pr = {1'b0, 7'(len), 8'(d)};
      if (d > 255 || len > 127) mErr = 1;
      else begin
        if (nb) begin
          if (mHalf) expWr({16'h0001, mHalfPair}, tag);
          expWr({4'h8, bw}, tag);
          mHalf = 1; mHalfPair = pr;
        end else if (mHalf) begin
          expWr({pr, mHalfPair}, tag);
          mHalf = 0;
        end else begin
          mHalf = 1; mHalfPair = pr;
        end
        mPrevBase = bw; mPrevOff = ow; mFirst = 0; mLenSum += len;
      end
    end
    inEnd = 1'b0; inBase = b; inOffset = 16'(off); inLen = 8'(len);
    drive(stalls);
  endtask

  task automatic sendEnd(input string tag);
    res_t r;
    int need, stalls;
    r.tag = tag;
    if (mFirst || mErr) begin
      r.err = 1; r.words = 0;
    end else begin
      if (mHalf) expWr({16'h0001, mHalfPair}, tag);
      expWr(32'h0, tag);
      need = (capMode && sinkSram) ? mCnt + mLenSum : mCnt;
      r.err = need > DEPTH;
      r.words = r.err ? 0 : mCnt;
    end
    expR.push_back(r);
    mFirst = 1; mErr = 0; mHalf = 0; mCnt = 0; mLenSum = 0; mPrevOff = 0;
    inEnd = 1'b1;
    drive(stalls);
    inEnd = 1'b0;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    wr_t w;
    res_t r;
    forever begin
      @(negedge clk);
      #2;
      if (rstN && memWe) begin
        if (expW.size() == 0) check(0, "R6/R10 unexpected write", memData, 0);
        else begin
          w = expW.pop_front();
          check(memAddr == 6'(w.addr), {w.tag, " addr"}, memAddr, w.addr);
          check(memData == w.data, {w.tag, " data"}, memData, w.data);
        end
      end
      if (rstN && done) begin
        if (expR.size() == 0) check(0, "R5 unexpected done", 1, 0);
        else begin
          r = expR.pop_front();
          check(error == r.err, {r.tag, " error"}, error, r.err);
          check(zeroReq == r.err, {r.tag, " zeroReq"}, zeroReq, r.err);
          check(listWords == 16'(r.words), {r.tag, " listWords"}, listWords, r.words);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!inReady && !memWe && !done && !error, "reset state R5", {inReady, memWe, done, error}, 0);
    @(negedge clk);

    // R1 R2 R3 R5: one base, three pairs
    sendEntry(32'h0000_1000, 0, 1, "R1 first base", s);
    sendEntry(32'h0000_1004, 8, 2, "R2 second pair", s);
    check(s == 0, "R2 no stall", s, 0);
    sendEntry(32'h0000_100C, 20, 3, "R3 delta", s);
    sendEnd("R5 flush+term");
    idle(3);

    // R1 R4: base change and backward offset, each with flush stall
    sendEntry(32'h0002_0000, 0, 1, "R1 base A", s);
    sendEntry(32'h0003_0000, 4, 1, "R4 base change flush", s);
    check(s == 1, "R4 stall on base change", s, 1);
    sendEntry(32'h0003_0000, 0, 5, "R1 backward offset", s);
    check(s == 1, "R4 stall on backward offset", s, 1);
    sendEntry(32'h0003_0000, 12, 4, "R3 delta after base", s);
    sendEnd("R5 list2");
    idle(2);

    // R3 boundary: delta 255, length 127 accepted (cap mode but list not via sram sink)
    sinkSram = 1'b0;
    sendEntry(32'h0004_0000, 0, 1, "R3 boundary first", s);
    sendEntry(32'h0004_0000, 1020, 127, "R3 delta255 len127", s);
    sendEnd("R3 boundary end");
    idle(2);

    // R6: delta 256 rejected, later entries ignored
    sendEntry(32'h0005_0000, 0, 1, "R6 ok entry", s);
    sendEntry(32'h0005_0000, 1024, 1, "R6 delta256", s);
    sendEntry(32'h0006_0000, 0, 1, "R6 ignored entry", s);
    sendEnd("R6 delta error");
    idle(2);
    // R6: length 128 rejected
    sendEntry(32'h0005_0000, 0, 128, "R6 len128", s);
    sendEnd("R6 length error");
    idle(2);

    // R7: empty list
    sendEnd("R7 empty list");
    idle(2);

    // R8: capture + sram sink counts data
    sinkSram = 1'b1;
    sendEntry(32'h0007_0000, 0, 60, "R8 fit", s);
    sendEnd("R8 3+60 fits");
    idle(2);
    sendEntry(32'h0007_0000, 0, 62, "R8 over", s);
    sendEnd("R8 3+62 overflow");
    idle(2);

    // R9: other modes ignore data size
    sinkSram = 1'b0;
    sendEntry(32'h0007_0000, 0, 62, "R9 trace sink", s);
    sendEnd("R9 list only");
    idle(2);
    capMode = 1'b0; sinkSram = 1'b1;
    sendEntry(32'h0007_0000, 0, 100, "R9 checksum mode", s);
    sendEnd("R9 checksum list only");
    idle(2);

    // R10: list longer than SRAM, writes stop at depth, next list restarts at 0
    for (int i = 0; i < 33; i++)
      sendEntry(32'h0010_0000 + 32'(i) * 32'h10, 0, 1, "R10 long list", s);
    sendEnd("R10 list overflow");
    idle(2);
    capMode = 1'b1;
    sendEntry(32'h0000_2000, 4, 2, "R10 restart at 0", s);
    sendEnd("R10 restart end");
    idle(4);

    check(expW.size() == 0, "R5 all writes seen", expW.size(), 0);
    check(expR.size() == 0, "R5 all results seen", expR.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule